// File: doc/BRIEF.md
# Two-Stage Watchdog Countdown Timer

This block is a watchdog core that supervises software by counting down from a programmed interval. The interval is held as a preload value. Each preload unit equals `2^PRESCALE_W` clock cycles because the preload fills the upper bits of a down counter. Counting runs in two chained stages, and each stage has its own preload. When the first stage runs out, the block can raise a sticky interrupt, and it then continues with the second preload. When the second stage runs out, the block either pulses a system reset request and sets a sticky timeout flag, or it returns quietly to the first stage and counts again.

Software keeps the watchdog quiet by kicking it. A kick forces the first stage and restarts the count. The host bus decoding sits outside this block. It presents plain strobes: one per preload write, one kick, and one clear each for the interrupt and the timeout flag.

There are two resets. `rst_n` is the reset that the watchdog itself causes, and it leaves the timeout flag untouched. `por_n` is the power-on reset, and it clears everything.

Top module: `wdog_two_stage`

## Requirements
- R1: After either reset, the block is in the first stage (`stage2`=0), and `irq` and `reset_req` are low. Both preloads equal all ones (`2^PRE_W-1`).
- R2: A preload write keeps only the low `PRE_W` bits of `wdata`. The upper bits have no effect on timing.
- R3: When enabled with preload P1, the first-stage expiry makes `stage2` rise `P1*2^PRESCALE_W+1` cycles after the start edge. The second stage then lasts `P2*2^PRESCALE_W+1` cycles.
- R4: On the first-stage expiry, `irq` is set when `irq_en` is high. When `irq_en` is low, `irq` stays low.
- R5: On the second-stage expiry with `reboot_en` high, `reset_req` is high for exactly one cycle. In that same cycle `timeout_flag` is set and the stage returns to the first.
- R6: On the second-stage expiry with `reboot_en` low, the stage returns to the first with no reset request. Counting restarts from P1.
- R7: A kick while enabled forces the first stage and restarts the count from P1. A kick that coincides with an expiry wins, and the expiry is lost.
- R8: While `enable` is low, the counter and the stage do not move. A low-to-high change of `enable` starts the first stage from P1.
- R9: `irq` stays high until an `irq_clr` pulse. Kicks and disabling do not clear it.
- R10: `timeout_flag` survives `rst_n`. It is cleared only by `tflag_clr` or `por_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears all state |
| rst_n | input | 1 | Functional reset, active low, synchronous; keeps the timeout flag |
| enable | input | 1 | Run control; a rising level starts the first stage |
| kick | input | 1 | Reload strobe |
| irq_en | input | 1 | Allows the interrupt on first-stage expiry |
| reboot_en | input | 1 | Selects a reset request on second-stage expiry |
| wr_pre1 | input | 1 | Write strobe for the first-stage preload |
| wr_pre2 | input | 1 | Write strobe for the second-stage preload |
| wdata | input | DATA_W | Preload write data; only the low PRE_W bits are kept |
| irq_clr | input | 1 | Clears the interrupt flag |
| tflag_clr | input | 1 | Clears the sticky timeout flag |
| irq | output | 1 | Sticky interrupt line |
| reset_req | output | 1 | One-cycle system reset request |
| timeout_flag | output | 1 | Sticky flag: a reset was requested |
| stage2 | output | 1 | High while the second stage counts |

## Verification
The bench builds the block with `PRE_W`=4 and `PRESCALE_W`=2, so a full stage lasts at most 61 cycles. This allows a sweep over all sixteen preload values for both stages, with garbage in the upper data bits. The expected durations are computed as `P*4+1`. The small widths also bring within reach the all-ones default after reset, the zero preload where an expiry follows one cycle after loading, and a kick landing in the exact expiry cycle.

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter int PRE_W      = 20,
  parameter int PRESCALE_W = 15,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              kick,
  input  logic              irq_en,
  input  logic              reboot_en,
  input  logic              wr_pre1,
  input  logic              wr_pre2,
  input  logic [DATA_W-1:0] wdata,
  input  logic              irq_clr,
  input  logic              tflag_clr,
  output logic              irq,
  output logic              reset_req,
  output logic              timeout_flag,
  output logic              stage2
);
  localparam int CW = PRE_W + PRESCALE_W;

  logic [PRE_W-1:0] pre1, pre2;
  logic [CW-1:0]    cnt;
  logic             en_q, stg, irq_act, req, tflag;

  wire          run     = enable & en_q;
  wire          start   = enable & ~en_q;
  wire          at_zero = (cnt == '0);
  wire          expire1 = run & ~kick & at_zero & ~stg;
  wire          expire2 = run & ~kick & at_zero & stg;
  wire [CW-1:0] load1   = {pre1, {PRESCALE_W{1'b0}}};
  wire [CW-1:0] load2   = {pre2, {PRESCALE_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) begin
      pre1    <= '1;
      pre2    <= '1;
      cnt     <= '0;
      en_q    <= 1'b0;
      stg     <= 1'b0;
      irq_act <= 1'b0;
      req     <= 1'b0;
    end else begin
      en_q <= enable;
      req  <= expire2 & reboot_en;
      if (wr_pre1) pre1 <= wdata[PRE_W-1:0];
      if (wr_pre2) pre2 <= wdata[PRE_W-1:0];
      if (expire1 && irq_en) irq_act <= 1'b1;
      else if (irq_clr)      irq_act <= 1'b0;
      if (kick || start) begin
        stg <= 1'b0;
        if (enable) cnt <= load1;
      end else if (run) begin
        if (!at_zero)  cnt <= cnt - 1'b1;
        else if (!stg) begin stg <= 1'b1; cnt <= load2; end
        else           begin stg <= 1'b0; cnt <= load1; end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n)                      tflag <= 1'b0;
    else if (expire2 && reboot_en)   tflag <= 1'b1;
    else if (tflag_clr)              tflag <= 1'b0;
  end

  assign irq          = irq_act;
  assign reset_req    = req;
  assign timeout_flag = tflag;
  assign stage2       = stg;

  p_req_pulse_r5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    reset_req |=> !reset_req);
  p_req_with_flag_r5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    reset_req |-> (timeout_flag && !stage2));
  p_irq_needs_en_r4: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $rose(irq) |-> $past(irq_en));
  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (irq && !irq_clr) |=> irq);
  p_tflag_survives_r10: assert property (@(posedge clk) disable iff (!por_n)
    (timeout_flag && !tflag_clr) |=> timeout_flag);
  p_disabled_hold_r8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (!enable && !kick) |=> $stable(stage2));
  p_kick_wins_r7: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (kick && enable) |=> (!stage2 && !reset_req));
endmodule

// File: tb/wdog_two_stage_bench.sv
module wdog_two_stage_bench;
  localparam int PW = 4;
  localparam int SW = 2;
  localparam int U  = 1 << SW;

  logic clk = 1'b0;
  logic por_n, rst_n, enable, kick, irq_en, reboot_en, wr_pre1, wr_pre2, irq_clr, tflag_clr;
  logic [31:0] wdata;
  logic irq, reset_req, timeout_flag, stage2;
  int checks = 0;
  int errors = 0;
  int req_seen = 0;

  always #4 clk = ~clk;

  wdog_two_stage #(.PRE_W(PW), .PRESCALE_W(SW), .DATA_W(32)) u_wdog_two_stage (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .enable(enable), .kick(kick),
    .irq_en(irq_en), .reboot_en(reboot_en), .wr_pre1(wr_pre1), .wr_pre2(wr_pre2),
    .wdata(wdata), .irq_clr(irq_clr), .tflag_clr(tflag_clr), .irq(irq),
    .reset_req(reset_req), .timeout_flag(timeout_flag), .stage2(stage2));

  always @(posedge clk) if (reset_req === 1'b1) req_seen <= req_seen + 1;

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic until_stage(logic want, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (stage2 !== want && n < 2000);
  endtask

  task automatic write_pre(bit which, int p, int junk);
    wdata = {28'(junk * 32'h0123_4567 + 5), 4'(p)};
    if (which) wr_pre2 = 1'b1; else wr_pre1 = 1'b1;
    tick();
    wr_pre1 = 1'b0; wr_pre2 = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    por_n = 0; rst_n = 0; enable = 0; kick = 0; irq_en = 0; reboot_en = 0;
    wr_pre1 = 0; wr_pre2 = 0; irq_clr = 0; tflag_clr = 0; wdata = '0;
    tick(3);
    por_n = 1; rst_n = 1;
    tick();
    chk("R1 stage", stage2, 0);
    chk("R1 irq", irq, 0);
    chk("R1 reset_req", reset_req, 0);
    chk("R10 flag after por", timeout_flag, 0);
    enable = 1;
    until_stage(1, n);
    chk("R1 default preload", n, 15 * U + 2);
    enable = 0; tick(2);

    for (int p = 0; p < 16; p++) begin
      write_pre(0, p, p + 3);
      write_pre(1, 15 - p, p + 9);
      enable = 1;
      until_stage(1, n);
      chk("R2 R3 stage1 length", n, p * U + 2);
      until_stage(0, n);
      chk("R3 stage2 length", n, (15 - p) * U + 1);
      until_stage(1, n);
      chk("R6 restart from P1", n, p * U + 1);
      enable = 0; tick(2);
    end
    chk("R6 no reset request", req_seen, 0);

    write_pre(0, 0, 1);
    write_pre(1, 15, 2);
    enable = 1; tick();
    kick = 1; tick();
    chk("R7 kick beats expiry", stage2, 0);
    kick = 0;
    until_stage(1, n);
    chk("R7 reload after kick", n, 1);
    enable = 0; tick(2);
    write_pre(0, 5, 3);
    enable = 1; tick(10);
    kick = 1; tick(); kick = 0;
    until_stage(1, n);
    chk("R7 kick restarts count", n, 5 * U + 1);
    enable = 0; tick(2);

    enable = 1; tick(10);
    enable = 0; tick(100);
    chk("R8 disabled stage1 holds", stage2, 0);
    enable = 1;
    until_stage(1, n);
    chk("R8 rise restarts P1", n, 5 * U + 2);
    enable = 0; tick(200);
    chk("R8 disabled stage2 holds", stage2, 1);
    enable = 1; tick();
    chk("R8 rise forces stage1", stage2, 0);
    enable = 0; tick(2);

    write_pre(0, 1, 4);
    irq_en = 1; enable = 1;
    until_stage(1, n);
    chk("R4 irq set", irq, 1);
    kick = 1; tick(); kick = 0;
    chk("R9 kick keeps irq", irq, 1);
    enable = 0; tick(50);
    chk("R9 irq held", irq, 1);
    irq_clr = 1; tick(); irq_clr = 0;
    chk("R9 irq cleared", irq, 0);
    irq_en = 0; enable = 1;
    until_stage(1, n);
    chk("R4 irq masked", irq, 0);
    enable = 0; tick(2);

    write_pre(0, 0, 5);
    write_pre(1, 0, 6);
    reboot_en = 1; enable = 1;
    tick(2);
    chk("R5 in stage2", stage2, 1);
    tick();
    chk("R5 reset_req", reset_req, 1);
    chk("R5 flag set", timeout_flag, 1);
    chk("R5 back to stage1", stage2, 0);
    enable = 0; tick();
    chk("R5 one-cycle pulse", reset_req, 0);
    rst_n = 0; tick(2); rst_n = 1; tick();
    chk("R10 flag survives rst_n", timeout_flag, 1);
    reboot_en = 0; enable = 1;
    until_stage(1, n);
    chk("R1 preload reset by rst_n", n, 15 * U + 2);
    enable = 0; tick(2);
    tflag_clr = 1; tick(); tflag_clr = 0;
    chk("R10 flag cleared by command", timeout_flag, 0);
    write_pre(0, 0, 7);
    write_pre(1, 0, 8);
    reboot_en = 1; enable = 1; tick(3);
    enable = 0; reboot_en = 0; tick();
    chk("R10 flag set again", timeout_flag, 1);
    por_n = 0; tick(2); por_n = 1; tick();
    chk("R10 flag cleared by por_n", timeout_flag, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule